// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the time of day and the calendar date in seven packed-BCD registers: seconds, minutes, hours, day of month, month, two-digit year and day of week. An internal prescaler divides the system clock down to a one-second step. Each step advances the seconds, and a carry runs up through the chain whenever a field passes its limit. The length of each month comes from the month and year registers, and February has a leap day whenever the two-digit year is a multiple of four.

A host sets a single field by putting an index on the load-select input and pulsing the load strobe. The new value appears one clock later, and every load restarts the second so that the next step comes a full second after it. The read port is combinational. It returns the packed byte of the field at the given index, and any bit that the field does not use reads as zero. Bit 7 of the hours byte selects the hour format: 1 gives a 24-hour count, and 0 gives a 12-hour count with bit 5 as the afternoon flag.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the bytes read at indices 0 to 6 are 00h, 00h, 00h, 01h, 01h, 00h, 00h (seconds, minutes, hours, date, month, year, weekday).
- R2: Unused bits read as zero: seconds and minutes bit 7, hours bit 6, date bits 7:6, month bits 7:5 and weekday bits 7:3. Indices 7 and above read 00h.
- R3: The seconds field, with tens in bits 6:4 and units in bits 3:0, advances once every CLK_HZ clocks. 09 steps to 10, and 59 steps to 00 with a carry into minutes.
- R4: The minutes field uses the seconds layout. 59 steps to 00 with a carry into hours.
- R5: When hours bit 7 is 1 (24-hour mode, tens in bits 5:4), 23 steps to 00 and advances the date and the weekday.
- R6: When hours bit 7 is 0 (12-hour mode, bit 5 = PM, tens in bit 4), 11 steps to 12 and toggles bit 5, and 12 steps to 01. Only the PM 11 to AM 12 step advances the date and the weekday.
- R7: The weekday (bits 2:0) counts 0 to 6, and 6 steps to 0.
- R8: The date steps to 01 and the month advances after day 30 in months 04, 06, 09 and 11, and after day 31 in every other month except 02.
- R9: In month 02 the date steps to 01 after day 29 when the year value is divisible by 4 (00 counts), and after day 28 otherwise.
- R10: Month 12 steps to 01 and advances the year. Year 99 steps to 00.
- R11: A load (ld_sel 0 to 6 = seconds, minutes, hours, date, month, year, weekday) is visible after the next clock edge with the unused bits cleared. No field advances in the load cycle, and the next advance comes exactly CLK_HZ clocks after the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load strobe for one field |
| ld_sel | input | 3 | Field index to load |
| ld_data | input | 8 | Packed BCD value to load |
| rd_addr | input | 3 | Field index to read |
| rd_data | output | 8 | Packed BCD byte of the selected field |

## Verification
The bench builds the block with CLK_HZ = 4, so one second lasts four clocks. At that length the exact clock of every step, and the hold through the three clocks before it, can be checked directly. Each scenario loads the fields to one second before a boundary and then watches a single step. In this way the end of a day in both hour formats, the 30-day, 31-day and February month ends in leap and common years, and the year wrap all come within a few thousand clocks.

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_en,
  input  logic [2:0] ld_sel,
  input  logic [7:0] ld_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);

  localparam int unsigned PW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [PW-1:0] PLAST = PW'(CLK_HZ - 1);

  logic [PW-1:0] presc_q;
  logic          tick, adv;
  logic [6:0]    sec_q, min_q;
  logic [7:0]    hr_q, yr_q;
  logic [5:0]    date_q;
  logic [4:0]    mon_q;
  logic [2:0]    dow_q;

  function automatic logic [7:0] inc8(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  assign tick = (presc_q == PLAST);
  assign adv  = tick && !ld_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                presc_q <= '0;
    else if (ld_en || tick)    presc_q <= '0;
    else                       presc_q <= presc_q + 1'b1;

  // seconds / minutes
  logic       sec_wrap, min_wrap;
  logic [7:0] sec_nx, min_nx;
  assign sec_wrap = ({1'b0, sec_q} == 8'h59);
  assign min_wrap = ({1'b0, min_q} == 8'h59);
  assign sec_nx   = sec_wrap ? 8'h00 : inc8({1'b0, sec_q});
  assign min_nx   = min_wrap ? 8'h00 : inc8({1'b0, min_q});

  logic min_step, hr_step;
  assign min_step = adv && sec_wrap;
  assign hr_step  = min_step && min_wrap;

  // hours
  logic       mode24, pm;
  logic [7:0] h24, h12, nx24, nx12;
  logic       pm_nx, day_flag;
  logic [7:0] hr_nx;
  assign mode24 = hr_q[7];
  assign pm     = hr_q[5];
  assign h24    = {2'b00, hr_q[5:0]};
  assign h12    = {3'b000, hr_q[4:0]};
  assign nx24   = (h24 == 8'h23) ? 8'h00 : inc8(h24);

  always_comb begin
    pm_nx = pm;
    if (h12 == 8'h11) begin
      nx12  = 8'h12;
      pm_nx = !pm;
    end else if (h12 == 8'h12) begin
      nx12 = 8'h01;
    end else begin
      nx12 = inc8(h12);
    end
  end

  assign day_flag = mode24 ? (h24 == 8'h23) : ((h12 == 8'h11) && pm);
  assign hr_nx    = mode24 ? {2'b10, nx24[5:0]} : {2'b00, pm_nx, nx12[4:0]};

  logic day_step;
  assign day_step = hr_step && day_flag;

  // date / month / year
  logic [7:0] ybin, last_day, date_nx;
  logic       leap, date_wrap, mon_wrap, yr_wrap;
  logic [7:0] mon_nx, yr_nx;
  assign ybin = ({4'b0, yr_q[7:4]} * 8'd10) + {4'b0, yr_q[3:0]};
  assign leap = (ybin[1:0] == 2'b00);

  always_comb
    case (mon_q)
      5'h02:                      last_day = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase

  assign date_wrap = ({2'b00, date_q} == last_day);
  assign date_nx   = date_wrap ? 8'h01 : inc8({2'b00, date_q});
  assign mon_wrap  = ({3'b000, mon_q} == 8'h12);
  assign mon_nx    = mon_wrap ? 8'h01 : inc8({3'b000, mon_q});
  assign yr_wrap   = (yr_q == 8'h99);
  assign yr_nx     = yr_wrap ? 8'h00 : inc8(yr_q);

  logic mon_step, yr_step;
  assign mon_step = day_step && date_wrap;
  assign yr_step  = mon_step && mon_wrap;

  // state
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sec_q  <= 7'h00;
      min_q  <= 7'h00;
      hr_q   <= 8'h00;
      date_q <= 6'h01;
      mon_q  <= 5'h01;
      yr_q   <= 8'h00;
      dow_q  <= 3'd0;
    end else if (ld_en) begin
      case (ld_sel)
        3'd0:    sec_q  <= ld_data[6:0];
        3'd1:    min_q  <= ld_data[6:0];
        3'd2:    hr_q   <= {ld_data[7], 1'b0, ld_data[5:0]};
        3'd3:    date_q <= ld_data[5:0];
        3'd4:    mon_q  <= ld_data[4:0];
        3'd5:    yr_q   <= ld_data;
        3'd6:    dow_q  <= ld_data[2:0];
        default: ;
      endcase
    end else begin
      if (adv)      sec_q  <= sec_nx[6:0];
      if (min_step) min_q  <= min_nx[6:0];
      if (hr_step)  hr_q   <= hr_nx;
      if (day_step) begin
        date_q <= date_nx[5:0];
        dow_q  <= (dow_q == 3'd6) ? 3'd0 : dow_q + 3'd1;
      end
      if (mon_step) mon_q  <= mon_nx[4:0];
      if (yr_step)  yr_q   <= yr_nx;
    end

  always_comb
    case (rd_addr)
      3'd0:    rd_data = {1'b0, sec_q};
      3'd1:    rd_data = {1'b0, min_q};
      3'd2:    rd_data = hr_q;
      3'd3:    rd_data = {2'b00, date_q};
      3'd4:    rd_data = {3'b000, mon_q};
      3'd5:    rd_data = yr_q;
      3'd6:    rd_data = {5'b00000, dow_q};
      default: rd_data = 8'h00;
    endcase

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk #(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_en,
  input logic [2:0] ld_sel,
  input logic [7:0] ld_data,
  input logic       tick,
  input logic [6:0] sec,
  input logic [6:0] min,
  input logic [7:0] hr,
  input logic [5:0] date,
  input logic [4:0] mon,
  input logic [7:0] yr,
  input logic [2:0] dow
);

  logic step, eod;
  assign step = tick && !ld_en;
  assign eod  = step && sec == 7'h59 && min == 7'h59 && (hr == 8'hA3 || hr == 8'h31);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_en) |=> ($stable(sec) && $stable(min) && $stable(hr) && $stable(date)
                           && $stable(mon) && $stable(yr) && $stable(dow)));

  p_load_sec_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_sel == 3'd0) |=> sec == $past(ld_data[6:0]));

  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (CLK_HZ > 1 && ld_en) |=> !tick);

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sec == 7'h59) |=> sec == 7'h00);

  p_min_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sec == 7'h59 && min == 7'h59) |=> min == 7'h00);

  p_day24_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sec == 7'h59 && min == 7'h59 && hr == 8'hA3) |=> (hr == 8'h80 && dow != $past(dow)));

  p_pm_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sec == 7'h59 && min == 7'h59 && !hr[7] && hr[4:0] == 5'h11) |=> hr[5] != $past(hr[5]));

  p_dow_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eod && dow == 3'd6) |=> dow == 3'd0);

  p_leap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eod && mon == 5'h02 && date == 6'h28 && yr == 8'h24) |=> date == 6'h29);

  p_year_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eod && mon == 5'h12 && date == 6'h31 && yr == 8'h99) |=> (yr == 8'h00 && mon == 5'h01));

endmodule

bind bcd_calendar bcd_calendar_chk #(.CLK_HZ(CLK_HZ)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
  .tick(tick), .sec(sec_q), .min(min_q), .hr(hr_q), .date(date_q),
  .mon(mon_q), .yr(yr_q), .dow(dow_q)
);

// File: tb/test_bcd_calendar.sv
`timescale 1ns/1ps
module test_bcd_calendar;
  localparam int unsigned HZ = 4;

  logic clk = 0, rst_n = 0, ld_en = 0;
  logic [2:0] ld_sel = 0, rd_addr = 0;
  logic [7:0] ld_data = 0, rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bcd_calendar #(.CLK_HZ(HZ)) i_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_data(ld_data), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic expect_field(string req, logic [2:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, $sformatf("field %0d", a), v, exp);
  endtask

  task automatic set_all(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] d,
                         logic [7:0] mo, logic [7:0] y, logic [7:0] w);
    logic [7:0] vals [7];
    vals = '{s, m, h, d, mo, y, w};
    @(negedge clk);
    ld_en = 1;
    for (int i = 0; i < 7; i++) begin
      ld_sel = 3'(i);
      ld_data = vals[i];
      @(negedge clk);
    end
    ld_en = 0;
  endtask

  task automatic one_sec();
    repeat (HZ) @(negedge clk);
  endtask

  task automatic t_reset();
    expect_field("R1", 0, 8'h00); expect_field("R1", 1, 8'h00);
    expect_field("R1", 2, 8'h00); expect_field("R1", 3, 8'h01);
    expect_field("R1", 4, 8'h01); expect_field("R1", 5, 8'h00);
    expect_field("R1", 6, 8'h00); expect_field("R2", 7, 8'h00);
  endtask

  task automatic t_mask();
    set_all(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h42, 8'hFF);
    expect_field("R2", 0, 8'h7F); expect_field("R2", 1, 8'h7F);
    expect_field("R2", 2, 8'hBF); expect_field("R2", 3, 8'h3F);
    expect_field("R2", 4, 8'h1F); expect_field("R11", 5, 8'h42);
    expect_field("R2", 6, 8'h07); expect_field("R2", 7, 8'h00);
  endtask

  task automatic t_sec_min();
    set_all(8'h09, 8'h30, 8'h85, 8'h05, 8'h03, 8'h20, 8'h01);
    repeat (HZ - 1) @(negedge clk);
    expect_field("R11", 0, 8'h09);
    @(negedge clk);
    expect_field("R3", 0, 8'h10);
    set_all(8'h58, 8'h59, 8'h90, 8'h05, 8'h03, 8'h20, 8'h01);
    one_sec();
    expect_field("R3", 0, 8'h59);
    one_sec();
    expect_field("R3", 0, 8'h00);
    expect_field("R4", 1, 8'h00);
    expect_field("R4", 2, 8'h91);
    expect_field("R4", 3, 8'h05);
  endtask

  task automatic t_day24();
    set_all(8'h59, 8'h59, 8'hA3, 8'h15, 8'h03, 8'h24, 8'h06);
    one_sec();
    expect_field("R5", 2, 8'h80);
    expect_field("R5", 3, 8'h16);
    expect_field("R7", 6, 8'h00);
    set_all(8'h59, 8'h59, 8'hA3, 8'h15, 8'h03, 8'h24, 8'h02);
    one_sec();
    expect_field("R7", 6, 8'h03);
  endtask

  task automatic t_12h();
    set_all(8'h59, 8'h59, 8'h11, 8'h10, 8'h06, 8'h24, 8'h02);
    one_sec();
    expect_field("R6", 2, 8'h32);
    expect_field("R6", 3, 8'h10);
    set_all(8'h59, 8'h59, 8'h32, 8'h10, 8'h06, 8'h24, 8'h02);
    one_sec();
    expect_field("R6", 2, 8'h21);
    set_all(8'h59, 8'h59, 8'h31, 8'h10, 8'h06, 8'h24, 8'h02);
    one_sec();
    expect_field("R6", 2, 8'h12);
    expect_field("R6", 3, 8'h11);
    expect_field("R6", 6, 8'h03);
  endtask

  task automatic eod_date(string req, logic [7:0] d, logic [7:0] mo, logic [7:0] y,
                          logic [7:0] ed, logic [7:0] emo, logic [7:0] ey);
    set_all(8'h59, 8'h59, 8'hA3, d, mo, y, 8'h00);
    one_sec();
    expect_field(req, 3, ed);
    expect_field(req, 4, emo);
    expect_field(req, 5, ey);
  endtask

  task automatic t_month_len();
    eod_date("R8", 8'h30, 8'h04, 8'h24, 8'h01, 8'h05, 8'h24);
    eod_date("R8", 8'h30, 8'h05, 8'h24, 8'h31, 8'h05, 8'h24);
    eod_date("R8", 8'h31, 8'h07, 8'h24, 8'h01, 8'h08, 8'h24);
    eod_date("R8", 8'h30, 8'h11, 8'h24, 8'h01, 8'h12, 8'h24);
  endtask

  task automatic t_feb();
    eod_date("R9", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24);
    eod_date("R9", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23);
    eod_date("R9", 8'h29, 8'h02, 8'h00, 8'h01, 8'h03, 8'h00);
    eod_date("R9", 8'h28, 8'h02, 8'h10, 8'h01, 8'h03, 8'h10);
    eod_date("R9", 8'h28, 8'h02, 8'h12, 8'h29, 8'h02, 8'h12);
  endtask

  task automatic t_year();
    eod_date("R10", 8'h31, 8'h12, 8'h45, 8'h01, 8'h01, 8'h46);
    eod_date("R10", 8'h31, 8'h12, 8'h99, 8'h01, 8'h01, 8'h00);
  endtask

  task automatic t_load_restart();
    set_all(8'h10, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00);
    repeat (2) @(negedge clk);
    ld_en = 1; ld_sel = 3'd0; ld_data = 8'h20;
    @(negedge clk);
    ld_en = 0;
    expect_field("R11", 0, 8'h20);
    expect_field("R11", 1, 8'h00);
    repeat (HZ - 1) @(negedge clk);
    expect_field("R11", 0, 8'h20);
    @(negedge clk);
    expect_field("R11", 0, 8'h21);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_mask();
    t_sec_min();
    t_day24();
    t_12h();
    t_month_len();
    t_feb();
    t_year();
    t_load_restart();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule